// File: doc/BRIEF.md
# Conversion Result Queue with Serial Byte Readout

This block collects converter results into a queue and delivers them to a host over a serial read port with an active-low select. Every queue entry is 16 bits wide and already carries its framing, so the read side only has to pick a byte and a bit. An ADC result is ten code bits plus two sub-bits below the LSB. A temperature result is a 12-bit two's complement value with 0.125 °C per LSB. Results of one scan are staged and become readable together when the scan closes. When a scan asks for a temperature reading, that reading is placed ahead of every ADC result of the scan, whatever order the converter delivers them in.

The host lowers the select line and receives bits MSB first. Each byte is eight clock cycles. Two bytes make one entry. When the select line rises partway through a byte, the rest of that byte is discarded and the next read starts at the following byte boundary. The reader never jumps to the start of the next entry. Select, serial clock and data are handled in the system clock domain. The two serial inputs pass through two-stage synchronisers, and their edges are found from the synchronised values.

Top module: `rfs_readout`

## Requirements
- R1: After reset, overflow is 0, dout is 0 while cs_n is high, and a read of the empty queue shifts out only zeros.
- R2: An ADC entry is read as two bytes, MSB first. The first byte is {0000, code[9:6]} and the second byte is {code[5:0], sub[1:0]}.
- R3: A push or a temperature-slot reservation made while the queue holds DEPTH entries (counting staged and reserved ones) is dropped, and overflow is set. Overflow stays set until reset.
- R4: The first bit of a byte appears on dout after cs_n falls. Later bits change only after a falling sclk edge. dout holds steady while sclk is high.
- R5: When cs_n rises after 1 to 7 rising sclk edges of an entry's first byte, the rest of that byte is lost. The next read starts with that entry's second byte.
- R6: When cs_n rises partway through an entry's second byte, the rest of that byte is lost. The next read starts with the first byte of the next entry.
- R7: A scan opened with scan_temp high stores its temperature entry, {0000, temp[11:0]}, ahead of all ADC entries of that scan, even when the temperature value arrives after them.
- R8: Entries of an open scan are not readable until scan_end. Until then, a read of an otherwise empty queue gives zeros.
- R9: Reading an empty queue does not move the read position. Data committed afterwards is read from its first byte.
- R10: When cs_n rises exactly on a byte boundary, no byte is skipped.
- R11: adc_push and temp_push outside an open scan are ignored. A temp_push in a scan without a reserved temperature slot is also ignored.
- R12: When a scan reserves a temperature slot but no temperature value arrives, that slot is read as an all-zero entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_start | input | 1 | Opens a scan (ignored while a scan is open) |
| scan_temp | input | 1 | With scan_start: reserve a temperature slot at the head of the scan |
| scan_end | input | 1 | Closes the open scan and makes its entries readable |
| adc_push | input | 1 | Stores one ADC result |
| adc_code | input | 10 | ADC result code (binary or two's complement) |
| adc_sub | input | 2 | Sub-bits below the LSB |
| temp_push | input | 1 | Fills the reserved temperature slot |
| temp_code | input | 12 | Temperature result, two's complement |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| dout | output | 1 | Serial data, MSB first |
| overflow | output | 1 | Sticky flag: a result was dropped because the queue was full |

## Verification
If the byte-select or bit-count state goes wrong, the next read shows it at once as bytes swapped or shifted relative to the expected framed entry. A read-pointer slip shows up as a whole entry skipped or repeated on the following 16 bits. A wrong occupancy count is seen on the overflow pin on the very push where the drop should or should not happen. The bench compares the overflow pin every clock cycle, and every dout bit both at the end of its low half and again before the next falling edge. A fault therefore shows within one serial bit time.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int CODE_W = 10;
  localparam int SUB_W  = 2;
  localparam int TEMP_W = 12;
  localparam int ENT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int PAD_W  = ENT_W - CODE_W - SUB_W;

  typedef logic [ENT_W-1:0]  entry_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Leading zero pad, result code, then sub-bits below the LSB.
  function automatic entry_t frame_adc(input logic [CODE_W-1:0] code,
                                       input logic [SUB_W-1:0]  sub);
    return {{PAD_W{1'b0}}, code, sub};
  endfunction

  // Temperature word right-aligned under a zero pad.
  function automatic entry_t frame_temp(input logic [TEMP_W-1:0] t);
    return {{(ENT_W-TEMP_W){1'b0}}, t};
  endfunction

  // Byte 0 is the upper half of the entry, byte 1 the lower half.
  function automatic byte_t pick_byte(input entry_t e, input logic second);
    return second ? e[BYTE_W-1:0] : e[ENT_W-1:BYTE_W];
  endfunction
endpackage

// File: rtl/rfs_store.sv
module rfs_store
  import rfs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_start,
  input  logic              scan_temp,
  input  logic              scan_end,
  input  logic              adc_push,
  input  logic [CODE_W-1:0] adc_code,
  input  logic [SUB_W-1:0]  adc_sub,
  input  logic              temp_push,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              pop,
  output entry_t            head,
  output logic              avail,
  output logic              drop,
  output logic [$clog2(DEPTH):0] occ
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  entry_t        mem [DEPTH];
  logic [AW:0]   wr_ptr, cm_ptr, rd_ptr, wr_nxt;
  logic [AW-1:0] tslot;
  logic          tslot_ok, open_q;
  logic          full, res_req, adc_req, res_ok, adc_ok, tmp_ok;

  always_comb begin
    occ     = wr_ptr - rd_ptr;
    full    = (occ == FULL_LVL);
    res_req = scan_start & ~open_q & scan_temp;
    adc_req = adc_push & open_q;
    res_ok  = res_req & ~full;
    adc_ok  = adc_req & ~full;
    tmp_ok  = temp_push & open_q & tslot_ok;
    drop    = (res_req | adc_req) & full;
    wr_nxt  = wr_ptr + {{AW{1'b0}}, (res_ok | adc_ok)};
    avail   = (cm_ptr != rd_ptr);
    head    = mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (res_ok) mem[wr_ptr[AW-1:0]] <= '0;
    if (adc_ok) mem[wr_ptr[AW-1:0]] <= frame_adc(adc_code, adc_sub);
    if (tmp_ok) mem[tslot]          <= frame_temp(temp_code);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      cm_ptr   <= '0;
      rd_ptr   <= '0;
      tslot    <= '0;
      tslot_ok <= 1'b0;
      open_q   <= 1'b0;
    end else begin
      wr_ptr <= wr_nxt;
      if (scan_start && !open_q) begin
        open_q   <= 1'b1;
        tslot_ok <= res_ok;
        tslot    <= wr_ptr[AW-1:0];
      end else if (scan_end && open_q) begin
        open_q   <= 1'b0;
        tslot_ok <= 1'b0;
        cm_ptr   <= wr_nxt;
      end else if (tmp_ok) begin
        tslot_ok <= 1'b0;
      end
      if (pop && avail) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/rfs_shift.sv
module rfs_shift
  import rfs_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_n,
  input  logic   sclk,
  input  entry_t head,
  input  logic   avail,
  output logic   pop,
  output logic   dout,
  output logic   load_ev,
  output logic   cs_edge,
  output logic   cs_act
);
  localparam int SYNC_N = 2;
  localparam int CNT_W  = $clog2(BYTE_W);

  logic [SYNC_N-1:0] cs_s, sc_s;
  logic              cs_d, sc_d, dout_q, bsel;
  logic [CNT_W-1:0]  bit_cnt;
  logic              cs_fall, cs_rise, sc_rise, sc_fall, advance;
  byte_t             cur_byte;

  always_comb begin
    cs_fall  = cs_d & ~cs_s[SYNC_N-1];
    cs_rise  = ~cs_d & cs_s[SYNC_N-1];
    sc_rise  = cs_act & ~sc_d & sc_s[SYNC_N-1];
    sc_fall  = cs_act & sc_d & ~sc_s[SYNC_N-1];
    cs_edge  = cs_fall | cs_rise;
    load_ev  = cs_fall | sc_fall;
    // Full byte finished, or select released partway through a byte.
    advance  = (sc_rise && bit_cnt == CNT_W'(BYTE_W-1)) ||
               (cs_rise && bit_cnt != '0);
    pop      = advance & avail & bsel;
    cur_byte = avail ? pick_byte(head, bsel) : '0;
    dout     = cs_act & dout_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s    <= '1;
      sc_s    <= '0;
      cs_d    <= 1'b1;
      sc_d    <= 1'b0;
      cs_act  <= 1'b0;
      dout_q  <= 1'b0;
      bsel    <= 1'b0;
      bit_cnt <= '0;
    end else begin
      cs_s <= {cs_s[SYNC_N-2:0], cs_n};
      sc_s <= {sc_s[SYNC_N-2:0], sclk};
      cs_d <= cs_s[SYNC_N-1];
      sc_d <= sc_s[SYNC_N-1];
      if (cs_fall) cs_act <= 1'b1;
      else if (cs_rise) cs_act <= 1'b0;
      if (load_ev) dout_q <= cur_byte[~bit_cnt];
      if (advance && avail) bsel <= ~bsel;
      if (cs_rise) bit_cnt <= '0;
      else if (sc_rise) bit_cnt <= bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rfs_readout.sv
module rfs_readout
  import rfs_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_start,
  input  logic              scan_temp,
  input  logic              scan_end,
  input  logic              adc_push,
  input  logic [CODE_W-1:0] adc_code,
  input  logic [SUB_W-1:0]  adc_sub,
  input  logic              temp_push,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic              cs_n,
  input  logic              sclk,
  output logic              dout,
  output logic              overflow
);
  localparam int AW = $clog2(DEPTH);

  entry_t      head;
  logic        avail, drop, pop, load_ev, cs_edge, cs_act;
  logic [AW:0] occ;

  rfs_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .scan_start(scan_start), .scan_temp(scan_temp), .scan_end(scan_end),
    .adc_push(adc_push), .adc_code(adc_code), .adc_sub(adc_sub),
    .temp_push(temp_push), .temp_code(temp_code),
    .pop(pop), .head(head), .avail(avail), .drop(drop), .occ(occ)
  );

  rfs_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
    .head(head), .avail(avail), .pop(pop), .dout(dout),
    .load_ev(load_ev), .cs_edge(cs_edge), .cs_act(cs_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) overflow <= 1'b0;
    else if (drop) overflow <= 1'b1;
  end
endmodule

// File: rtl/rfs_checks.sv
module rfs_checks #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   load_ev,
  input logic                   cs_edge,
  input logic                   cs_act,
  input logic                   dout,
  input logic                   overflow,
  input logic                   drop,
  input logic                   pop,
  input logic                   avail,
  input logic [$clog2(DEPTH):0] occ
);
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_drop_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overflow);
  p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= ($clog2(DEPTH)+1)'(DEPTH));
  p_dout_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_ev && !cs_edge) |=> $stable(dout));
  p_pop_avail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> avail);
  p_pop_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cs_act);
endmodule

bind rfs_readout rfs_checks #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_ev(load_ev), .cs_edge(cs_edge),
  .cs_act(cs_act), .dout(dout), .overflow(overflow), .drop(drop),
  .pop(pop), .avail(avail), .occ(occ)
);

// File: tb/rfs_readout_bench.sv
module rfs_readout_bench;
  localparam int CLK_PER = 10;
  localparam int DEPTH   = 16;
  localparam int H       = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scan_start = 0, scan_temp = 0, scan_end = 0;
  logic adc_push = 0, temp_push = 0;
  logic [9:0] adc_code = '0;
  logic [1:0] adc_sub = '0;
  logic [11:0] temp_code = '0;
  logic cs_n = 1'b1, sclk = 1'b0;
  logic dout, overflow;

  rfs_readout #(.DEPTH(DEPTH)) u_rfs_readout (
    .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .scan_temp(scan_temp),
    .scan_end(scan_end), .adc_push(adc_push), .adc_code(adc_code),
    .adc_sub(adc_sub), .temp_push(temp_push), .temp_code(temp_code),
    .cs_n(cs_n), .sclk(sclk), .dout(dout), .overflow(overflow)
  );

  always #(CLK_PER/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model: committed queue, staged scan, serial position.
  logic [15:0] q[$];
  logic [15:0] stage[$];
  int  tidx = 0, cnt = 0;
  bit  tres = 0, m_open = 0, m_ovf = 0, m_bsel = 0;

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_clk(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic m_bit();
    logic [15:0] e;
    logic [7:0]  b;
    if (q.size() == 0) return 1'b0;
    e = q[0];
    b = m_bsel ? e[7:0] : e[15:8];
    return b[7-cnt];
  endfunction

  function automatic void m_adv();
    if (q.size() != 0) begin
      if (m_bsel) void'(q.pop_front());
      m_bsel = ~m_bsel;
    end
  endfunction

  task automatic rd(input int n, input string tag);
    logic e;
    cs_n = 0;
    wait_clk(H);
    for (int i = 0; i < n; i++) begin
      e = m_bit();
      chk(dout, e, tag);
      sclk = 1;
      cnt++;
      if (cnt == 8) begin cnt = 0; m_adv(); end
      wait_clk(H);
      chk(dout, e, "R4 dout held while sclk high");
      sclk = 0;
      wait_clk(H);
    end
    cs_n = 1;
    if (cnt != 0) m_adv();
    cnt = 0;
    wait_clk(2*H);
  endtask

  task automatic start_scan(input bit t);
    scan_start = 1; scan_temp = t;
    @(posedge clk);
    if (!m_open) begin
      m_open = 1; tres = 0;
      if (t) begin
        if (q.size() + stage.size() >= DEPTH) m_ovf = 1;
        else begin stage.push_back(16'h0); tidx = stage.size()-1; tres = 1; end
      end
    end
    @(negedge clk);
    scan_start = 0; scan_temp = 0;
  endtask

  task automatic push_adc(input logic [9:0] c, input logic [1:0] s);
    adc_push = 1; adc_code = c; adc_sub = s;
    @(posedge clk);
    if (m_open) begin
      if (q.size() + stage.size() >= DEPTH) m_ovf = 1;
      else stage.push_back({4'b0000, c, s});
    end
    @(negedge clk);
    adc_push = 0;
  endtask

  task automatic push_temp(input logic [11:0] t);
    temp_push = 1; temp_code = t;
    @(posedge clk);
    if (m_open && tres) begin stage[tidx] = {4'b0000, t}; tres = 0; end
    @(negedge clk);
    temp_push = 0;
  endtask

  task automatic end_scan();
    scan_end = 1;
    @(posedge clk);
    if (m_open) begin
      foreach (stage[i]) q.push_back(stage[i]);
      stage.delete();
      m_open = 0; tres = 0;
    end
    @(negedge clk);
    scan_end = 0;
  endtask

  // Overflow pin compared to the model on every clock (R3).
  always @(negedge clk) begin
    if (rst_n && !done) chk(overflow, m_ovf, "R3 overflow per-clock");
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    chk(dout, 1'b0, "R1 dout at reset");
    chk(overflow, 1'b0, "R1 overflow at reset");
    rst_n = 1;
    wait_clk(3);
    chk(dout, 1'b0, "R1 dout idle after reset");
    rd(8, "R1 R9 empty read zeros");

    // R8: staged results stay hidden until scan_end.
    start_scan(0);
    push_adc(10'h2A5, 2'd2);
    push_adc(10'h155, 2'd1);
    push_adc(10'h3FF, 2'd3);
    rd(8, "R8 staged entries hidden");
    end_scan();
    rd(16, "R2 R9 framing first entry");
    rd(16, "R2 framing second entry");

    // R5: partial first byte, then resume at second byte.
    rd(3, "R5 partial first byte");
    rd(8, "R5 resume at second byte");

    // R7: temperature ahead of ADC results; R6 partial second byte.
    start_scan(1);
    push_adc(10'h001, 2'd0);
    push_temp(12'hF38);
    push_adc(10'h200, 2'd1);
    end_scan();
    rd(16, "R7 temperature first");
    rd(13, "R6 partial second byte");
    rd(16, "R6 next entry after partial");

    // R10: select released on a byte boundary.
    start_scan(0);
    push_adc(10'h0F0, 2'd2);
    end_scan();
    rd(8, "R10 first byte");
    rd(8, "R10 second byte after boundary release");

    // R12: reserved temperature slot left unfilled.
    start_scan(1);
    push_adc(10'h333, 2'd1);
    end_scan();
    rd(32, "R12 unfilled slot reads zero");

    // R11: pushes outside a scan and unreserved temp push are ignored.
    push_adc(10'h3C3, 2'd3);
    push_temp(12'h7FF);
    start_scan(0);
    push_temp(12'h123);
    push_adc(10'h0AA, 2'd0);
    end_scan();
    rd(32, "R11 ignored pushes");

    // R3: fill to DEPTH, one more is dropped.
    start_scan(0);
    for (int i = 0; i < DEPTH + 1; i++) push_adc(10'(i * 37 + 5), 2'(i));
    end_scan();
    chk(overflow, 1'b1, "R3 overflow after drop");
    for (int i = 0; i < DEPTH + 1; i++) rd(16, "R3 drained entries");
    chk(overflow, 1'b1, "R3 overflow sticky");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule